// File: doc/BRIEF.md
# Cell Measurement and Balancing Sequencer

This block paces the voltage checks and the balancing shunts of a series stack holding 5 to 10 lithium cells. A slot tick arrives at one thirty-second of the discharge-overcurrent delay. The block groups 128 slots into one measurement period. In the first five slots of a period the cell voltages are held and compared in a fixed order against five levels: undervoltage, undervoltage release, charge enable, overvoltage and balance. The block tells the analog front end which level to present and supplies that level in millivolts. The comparator results are captured one slot at a time.

When the fifth slot ends, the block evaluates the period. It updates two qualification counters, one for overvoltage and one for undervoltage, and a fault flag is raised only after 32 periods in a row show the condition. It also refreshes two stack summaries and latches which cells sit above the balance level. During the remaining 123 slots it drives per-cell shunt enables. Shunts go to even-numbered cells in one period and to odd-numbered cells in the next. The cell count comes from two three-level select inputs, and cells above the count are left out of every decision.

Top module: `cell_bal_sequencer`

## Requirements
- R1: A slot advances only on a `slot_tick` cycle, and a period is 128 slots. `meas_strobe` is high throughout slot 0. In slots 0 to 4, `thr_sel` equals the slot number, with the order undervoltage=0, release=1, charge enable=2, overvoltage=3, balance=4. Outside those slots `thr_sel` is 0.
- R2: `thr_mv` gives the level for `thr_sel` in millivolts. Undervoltage is 2300 and release is 2800. Overvoltage is 4100 + 50·min(`ov_code`,8). Charge enable is the overvoltage level minus 150.
- R3: The balance level is the overvoltage level minus 50·min(`bal_ofs_code`,8), and it never goes below 3750.
- R4: Each select input is coded 00 low, 01 mid, 10 high; 11 counts as high. If `cnt_sel_hi` is low, `cnt_sel_lo` picks 5, 6 or 7 cells. If it is mid, `cnt_sel_lo` picks 8, 9 or 10. If it is high, the count is 10. Bit i stands for cell i+1.
- R5: Cells above the count do not affect any flag, summary or shunt.
- R6: `ov_flag` is high when each of the last 32 evaluated periods had some counted cell above the overvoltage level. A period without that condition clears the count, and the count saturates at 32.
- R7: `uv_flag` follows the same rule for a counted cell that is not above the undervoltage level.
- R8: `all_below_ce` (no counted cell above charge enable) and `all_above_uvrel` (every counted cell above release) change only when a period is evaluated.
- R9: A shunt turns on only when all of these hold: `bal_enable` and `chg_det` are high, `bal_ofs_code` is nonzero, and the cell was above the balance level at the last evaluation.
- R10: The first period after reset balances even-numbered cells (odd bit indices). The parity then alternates every period.
- R11: All shunts are off in slots 0 to 4 and while `asleep` is high.
- R12: After reset the block is in slot 0 with both counters cleared, the summaries low, and no cell marked for balancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse per slot |
| cmp_hi | input | 10 | Per-cell result: cell above the presented level |
| cnt_sel_lo | input | 2 | Low-order three-level cell-count select |
| cnt_sel_hi | input | 2 | High-order three-level cell-count select |
| ov_code | input | 4 | Overvoltage level step (0 to 8) |
| bal_ofs_code | input | 4 | Balance offset below overvoltage, 0 disables |
| bal_enable | input | 1 | Balancing permitted |
| chg_det | input | 1 | Charger detected |
| asleep | input | 1 | Controller is in its low-power state |
| meas_strobe | output | 1 | Sample-and-hold window, slot 0 |
| thr_sel | output | 3 | Index of the level being compared |
| thr_mv | output | 13 | Level for `thr_sel` in millivolts |
| shunt_en | output | 10 | Per-cell balance shunt enables |
| ov_flag | output | 1 | Qualified overvoltage |
| uv_flag | output | 1 | Qualified undervoltage |
| all_below_ce | output | 1 | No counted cell above charge enable |
| all_above_uvrel | output | 1 | Every counted cell above release |

## Verification
The assertions take for granted that `slot_tick` is a single-cycle pulse. They also assume that the comparator vector follows the presented level within the slot, and that the count, code and enable inputs change only at period boundaries. The bench models cell voltages in millivolts. It derives `cmp_hi` combinationally from the current `thr_sel`, so each comparison matches the slot that asked for it. It changes configuration and voltages only between periods, spaces ticks two cycles apart, and mixes random stacks with directed long runs that hold a fault through its qualification boundary.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int MAX_CELLS    = 10;
    localparam int PERIOD_SLOTS = 128;
    localparam int MEAS_SLOTS   = 5;
    localparam int QUAL_PERIODS = 32;
    localparam int MV_W         = 13;
    localparam int UV_MV        = 2300;
    localparam int UVREL_MV     = 2800;
    localparam int OV_BASE_MV   = 4100;
    localparam int STEP_MV      = 50;
    localparam int CE_DROP_MV   = 150;
    localparam int BAL_FLOOR_MV = 3750;
    localparam int CODE_MAX     = 8;

    typedef enum logic [2:0] {
        THR_UV    = 3'd0,
        THR_UVREL = 3'd1,
        THR_CE    = 3'd2,
        THR_OV    = 3'd3,
        THR_BAL   = 3'd4
    } thr_e;

    typedef enum logic [1:0] {
        TRI_LOW  = 2'b00,
        TRI_MID  = 2'b01,
        TRI_HIGH = 2'b10,
        TRI_RSVD = 2'b11
    } tri_e;

    typedef struct packed {
        logic uv_any;
        logic ov_any;
        logic none_above_ce;
        logic all_above_rel;
    } verdict_t;

    function automatic int tri_rank(input logic [1:0] code);
        case (tri_e'(code))
            TRI_LOW: return 0;
            TRI_MID: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int cell_count(input logic [1:0] hi, input logic [1:0] lo);
        int hr;
        hr = tri_rank(hi);
        if (hr == 2) return MAX_CELLS;
        return 5 + 3 * hr + tri_rank(lo);
    endfunction

    function automatic logic [MV_W-1:0] level_mv(input logic [2:0] sel,
                                                 input logic [3:0] ovc,
                                                 input logic [3:0] ofs);
        int ov;
        int bal;
        int r;
        ov  = OV_BASE_MV + STEP_MV * ((int'(ovc) > CODE_MAX) ? CODE_MAX : int'(ovc));
        bal = ov - STEP_MV * ((int'(ofs) > CODE_MAX) ? CODE_MAX : int'(ofs));
        if (bal < BAL_FLOOR_MV) bal = BAL_FLOOR_MV;
        case (thr_e'(sel))
            THR_UV:    r = UV_MV;
            THR_UVREL: r = UVREL_MV;
            THR_CE:    r = ov - CE_DROP_MV;
            THR_OV:    r = ov;
            THR_BAL:   r = bal;
            default:   r = 0;
        endcase
        return MV_W'(r);
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int PERIOD_SLOTS = cbs_pkg::PERIOD_SLOTS,
    parameter int MEAS_SLOTS   = cbs_pkg::MEAS_SLOTS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output logic       measuring,
    output logic       first_slot,
    output logic       eval,
    output logic       phase_odd,
    output logic [2:0] meas_idx
);
    localparam int SW = $clog2(PERIOD_SLOTS);
    localparam logic [SW-1:0] LAST = SW'(PERIOD_SLOTS - 1);
    localparam logic [SW-1:0] MEAS_END = SW'(MEAS_SLOTS);

    logic [SW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '0;
            phase_odd <= 1'b0;
        end else if (tick) begin
            if (slot == LAST) begin
                slot      <= '0;
                phase_odd <= ~phase_odd;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign measuring  = (slot < MEAS_END);
    assign first_slot = (slot == '0);
    assign eval       = tick && (slot == MEAS_END - 1'b1);
    assign meas_idx   = measuring ? slot[2:0] : 3'd0;

    // R1
    slot_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(slot) |-> $past(tick));
    // R10
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_odd) |-> ($past(tick) && $past(slot) == LAST));
endmodule

// File: rtl/qual_counter.sv
module qual_counter #(
    parameter int QUAL = cbs_pkg::QUAL_PERIODS
) (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic cond,
    output logic flag
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] TOP = CW'(QUAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (upd) begin
            if (!cond)          cnt <= '0;
            else if (cnt != TOP) cnt <= cnt + 1'b1;
        end
    end

    assign flag = (cnt == TOP);

    // R6 R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(upd && cond));
    // R6 R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !upd) |=> flag);
endmodule

// File: rtl/meas_capture.sv
module meas_capture #(
    parameter int N    = cbs_pkg::MAX_CELLS,
    parameter int QUAL = cbs_pkg::QUAL_PERIODS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         measuring,
    input  logic         eval,
    input  logic [2:0]   idx,
    input  logic [N-1:0] cmp,
    input  logic [N-1:0] mask,
    output logic [N-1:0] bal_above,
    output logic         ov_flag,
    output logic         uv_flag,
    output logic         all_below_ce,
    output logic         all_above_rel
);
    import cbs_pkg::*;

    logic [N-1:0] cap_uv, cap_rel, cap_ce, cap_ov;
    verdict_t     vd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_uv <= '0;
            cap_rel <= '0;
            cap_ce <= '0;
            cap_ov <= '0;
        end else if (tick && measuring) begin
            case (thr_e'(idx))
                THR_UV:    cap_uv  <= cmp;
                THR_UVREL: cap_rel <= cmp;
                THR_CE:    cap_ce  <= cmp;
                THR_OV:    cap_ov  <= cmp;
                default:   ;
            endcase
        end
    end

    always_comb begin
        vd.uv_any        = |(~cap_uv & mask);
        vd.ov_any        = |(cap_ov & mask);
        vd.none_above_ce = ~|(cap_ce & mask);
        vd.all_above_rel = &(cap_rel | ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bal_above     <= '0;
            all_below_ce  <= 1'b0;
            all_above_rel <= 1'b0;
        end else if (eval) begin
            bal_above     <= cmp & mask;
            all_below_ce  <= vd.none_above_ce;
            all_above_rel <= vd.all_above_rel;
        end
    end

    qual_counter #(.QUAL(QUAL)) u_ov (
        .clk(clk), .rst(rst), .upd(eval), .cond(vd.ov_any), .flag(ov_flag));
    qual_counter #(.QUAL(QUAL)) u_uv (
        .clk(clk), .rst(rst), .upd(eval), .cond(vd.uv_any), .flag(uv_flag));

    // R8
    summary_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eval |=> ($stable(all_below_ce) && $stable(all_above_rel)));
    // R5
    bal_mask_chk: assert property (@(posedge clk) disable iff (rst)
        eval |=> ((bal_above & ~$past(mask)) == '0));
endmodule

// File: rtl/shunt_gate.sv
module shunt_gate #(
    parameter int N = cbs_pkg::MAX_CELLS
) (
    input  logic         measuring,
    input  logic         phase_odd,
    input  logic         asleep,
    input  logic         bal_enable,
    input  logic         chg_det,
    input  logic [3:0]   ofs_code,
    input  logic [N-1:0] bal_above,
    input  logic [N-1:0] mask,
    output logic [N-1:0] shunt
);
    logic allow;
    assign allow = !measuring && !asleep && bal_enable && chg_det && (ofs_code != 4'd0);

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam bit EVEN_CELL = ((i % 2) == 1);
        assign shunt[i] = allow && bal_above[i] && mask[i] && (EVEN_CELL == !phase_odd);
    end
endmodule

// File: rtl/cell_bal_sequencer.sv
module cell_bal_sequencer #(
    parameter int N            = cbs_pkg::MAX_CELLS,
    parameter int PERIOD_SLOTS = cbs_pkg::PERIOD_SLOTS,
    parameter int MEAS_SLOTS   = cbs_pkg::MEAS_SLOTS,
    parameter int QUAL         = cbs_pkg::QUAL_PERIODS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     slot_tick,
    input  logic [N-1:0]             cmp_hi,
    input  logic [1:0]               cnt_sel_lo,
    input  logic [1:0]               cnt_sel_hi,
    input  logic [3:0]               ov_code,
    input  logic [3:0]               bal_ofs_code,
    input  logic                     bal_enable,
    input  logic                     chg_det,
    input  logic                     asleep,
    output logic                     meas_strobe,
    output logic [2:0]               thr_sel,
    output logic [cbs_pkg::MV_W-1:0] thr_mv,
    output logic [N-1:0]             shunt_en,
    output logic                     ov_flag,
    output logic                     uv_flag,
    output logic                     all_below_ce,
    output logic                     all_above_uvrel
);
    import cbs_pkg::*;

    logic         measuring, eval, phase_odd;
    logic [N-1:0] mask, bal_above;
    int           ncells;

    seq_timer #(.PERIOD_SLOTS(PERIOD_SLOTS), .MEAS_SLOTS(MEAS_SLOTS)) u_timer (
        .clk(clk), .rst(rst), .tick(slot_tick), .measuring(measuring),
        .first_slot(meas_strobe), .eval(eval), .phase_odd(phase_odd), .meas_idx(thr_sel));

    assign ncells = cell_count(cnt_sel_hi, cnt_sel_lo);
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign mask[i] = (i < ncells);
    end

    assign thr_mv = level_mv(thr_sel, ov_code, bal_ofs_code);

    meas_capture #(.N(N), .QUAL(QUAL)) u_meas (
        .clk(clk), .rst(rst), .tick(slot_tick), .measuring(measuring), .eval(eval),
        .idx(thr_sel), .cmp(cmp_hi), .mask(mask), .bal_above(bal_above),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .all_below_ce(all_below_ce),
        .all_above_rel(all_above_uvrel));

    shunt_gate #(.N(N)) u_shunt (
        .measuring(measuring), .phase_odd(phase_odd), .asleep(asleep),
        .bal_enable(bal_enable), .chg_det(chg_det), .ofs_code(bal_ofs_code),
        .bal_above(bal_above), .mask(mask), .shunt(shunt_en));

    // R11
    shunt_meas_off_chk: assert property (@(posedge clk) disable iff (rst)
        meas_strobe |-> (shunt_en == '0));
    // R5
    shunt_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (shunt_en & ~mask) == '0);
    // R9
    shunt_needs_charger_chk: assert property (@(posedge clk) disable iff (rst)
        (!chg_det || !bal_enable) |-> (shunt_en == '0));
endmodule

// File: tb/cell_bal_sequencer_test.sv
module cell_bal_sequencer_test;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_tick = 1'b0;
    logic [N-1:0] cmp_hi;
    logic [1:0]  cnt_sel_lo = 2'b10, cnt_sel_hi = 2'b10;
    logic [3:0]  ov_code = 4'd2, bal_ofs_code = 4'd2;
    logic        bal_enable = 1'b1, chg_det = 1'b1, asleep = 1'b0;
    logic        meas_strobe, ov_flag, uv_flag, all_below_ce, all_above_uvrel;
    logic [2:0]  thr_sel;
    logic [12:0] thr_mv;
    logic [N-1:0] shunt_en;

    int volt [N];
    int tests = 0, fails = 0, period_idx = 0;
    int m_ovc = 0, m_uvc = 0;
    bit m_bal [N];
    bit m_below = 0, m_rel = 0;

    always #2.5 clk = ~clk;

    cell_bal_sequencer uut (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .cmp_hi(cmp_hi),
        .cnt_sel_lo(cnt_sel_lo), .cnt_sel_hi(cnt_sel_hi), .ov_code(ov_code),
        .bal_ofs_code(bal_ofs_code), .bal_enable(bal_enable), .chg_det(chg_det),
        .asleep(asleep), .meas_strobe(meas_strobe), .thr_sel(thr_sel), .thr_mv(thr_mv),
        .shunt_en(shunt_en), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .all_below_ce(all_below_ce), .all_above_uvrel(all_above_uvrel));

    function automatic int blevel(int sel, int ovc, int ofs);
        int ov, bal;
        ov  = 4100 + 50 * (ovc > 8 ? 8 : ovc);
        bal = ov - 50 * (ofs > 8 ? 8 : ofs);
        if (bal < 3750) bal = 3750;
        case (sel)
            0: return 2300;
            1: return 2800;
            2: return ov - 150;
            3: return ov;
            4: return bal;
            default: return 0;
        endcase
    endfunction

    function automatic int rank(logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    function automatic int bcount(logic [1:0] hi, logic [1:0] lo);
        if (rank(hi) == 2) return 10;
        return (rank(hi) == 0 ? 5 : 8) + rank(lo);
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++)
            cmp_hi[i] = (volt[i] > blevel(int'(thr_sel), int'(ov_code), int'(bal_ofs_code)));
    end

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_eval();
        int  c;
        bit  uvany, ovany;
        c = bcount(cnt_sel_hi, cnt_sel_lo);
        uvany = 0; ovany = 0; m_below = 1; m_rel = 1;
        for (int i = 0; i < N; i++) begin
            m_bal[i] = (i < c) && (volt[i] > blevel(4, ov_code, bal_ofs_code));
            if (i < c) begin
                if (volt[i] <= 2300) uvany = 1;
                if (volt[i] > blevel(3, ov_code, bal_ofs_code)) ovany = 1;
                if (volt[i] > blevel(2, ov_code, bal_ofs_code)) m_below = 0;
                if (volt[i] <= 2800) m_rel = 0;
            end
        end
        m_ovc = ovany ? (m_ovc == 32 ? 32 : m_ovc + 1) : 0;
        m_uvc = uvany ? (m_uvc == 32 ? 32 : m_uvc + 1) : 0;
    endtask

    function automatic int exp_shunt();
        int  r;
        bit  allow;
        allow = !asleep && bal_enable && chg_det && (bal_ofs_code != 0);
        r = 0;
        for (int i = 0; i < N; i++)
            if (allow && m_bal[i] && (((i % 2) == 1) == ((period_idx % 2) == 0)))
                r |= (1 << i);
        return r;
    endfunction

    task automatic do_period();
        for (int s = 0; s < 128; s++) begin
            @(negedge clk);
            if (s < 5) begin
                chk("R1 thr_sel", int'(thr_sel), s);
                chk("R2 R3 thr_mv", int'(thr_mv), blevel(s, ov_code, bal_ofs_code));
            end
            if (s == 0 || s == 5) chk("R1 meas_strobe", int'(meas_strobe), s == 0 ? 1 : 0);
            if (s == 2) chk("R11 shunts off while measuring", int'(shunt_en), 0);
            if (s == 4) model_eval();
            if (s == 5 || s == 90) begin
                chk("R6 ov_flag", int'(ov_flag), int'(m_ovc == 32));
                chk("R7 uv_flag", int'(uv_flag), int'(m_uvc == 32));
                chk("R8 all_below_ce", int'(all_below_ce), int'(m_below));
                chk("R8 all_above_uvrel", int'(all_above_uvrel), int'(m_rel));
                chk("R9 R10 R4 shunt_en", int'(shunt_en), exp_shunt());
            end
            slot_tick = 1'b1;
            @(negedge clk);
            slot_tick = 1'b0;
        end
        period_idx++;
    endtask

    task automatic set_all(int v);
        for (int i = 0; i < N; i++) volt[i] = v;
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        set_all(3800);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 strobe", int'(meas_strobe), 1);
        chk("R12 flags", int'({ov_flag, uv_flag}), 0);
        chk("R12 summaries", int'({all_below_ce, all_above_uvrel}), 0);
        chk("R12 shunts", int'(shunt_en), 0);

        // R6 overvoltage held across the 32-period boundary, then cleared
        set_all(3900); volt[3] = 4300;
        repeat (34) do_period();
        chk("R6 saturated", int'(ov_flag), 1);
        set_all(3900);
        do_period();
        chk("R6 cleared", int'(ov_flag), 0);

        // R7 undervoltage on cell 1
        set_all(3700); volt[0] = 2100;
        repeat (33) do_period();
        chk("R7 set", int'(uv_flag), 1);

        // R5 undervoltage on an uncounted cell is ignored
        cnt_sel_hi = 2'b00; cnt_sel_lo = 2'b00;
        set_all(4000); volt[7] = 2000; volt[9] = 4600;
        repeat (3) do_period();
        chk("R5 uncounted cells ignored", int'({ov_flag, uv_flag}), 0);

        // R3 floor of the balance level
        ov_code = 4'd0; bal_ofs_code = 4'd8;
        do_period();

        // R11 asleep, R9 offset zero
        cnt_sel_hi = 2'b10; set_all(4300); ov_code = 4'd6; bal_ofs_code = 4'd3;
        asleep = 1'b1; do_period();
        asleep = 1'b0; bal_ofs_code = 4'd0; do_period();
        bal_ofs_code = 4'd3; repeat (2) do_period();

        // R4 every select combination
        for (int h = 0; h < 4; h++)
            for (int l = 0; l < 4; l++) begin
                cnt_sel_hi = 2'(h); cnt_sel_lo = 2'(l);
                do_period();
            end

        // random stacks
        for (int p = 0; p < 40; p++) begin
            cnt_sel_hi = 2'($urandom_range(0, 3));
            cnt_sel_lo = 2'($urandom_range(0, 3));
            ov_code = 4'($urandom_range(0, 10));
            bal_ofs_code = 4'($urandom_range(0, 9));
            bal_enable = 1'($urandom_range(0, 3) != 0);
            chg_det = 1'($urandom_range(0, 3) != 0);
            asleep = 1'($urandom_range(0, 5) == 0);
            for (int i = 0; i < N; i++)
                volt[i] = ($urandom_range(0, 9) == 0) ? $urandom_range(2000, 2900)
                                                       : $urandom_range(3600, 4600);
            do_period();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule